// File: doc/BRIEF.md
# Selectable Half-Band Interpolation Chain

This block raises the sample rate of a complex baseband stream (an I rail and a Q rail) by a factor chosen at run time: 1 (straight pass), 2, 4, 8 or 16. It contains four 2× half-band stages in a row. A mode code sets how many of them are in use, starting from the head of the chain. Stages past that count get no enable strobes, so their registers hold and do not toggle. A single fast clock drives everything. A free-running phase counter divides that clock down, so that each stage in use is enabled at its own rate. The last stage in use produces a new output sample on every fast clock.

The source offers one sample per input-rate slot. The block publishes a strobe vector: bit 0 marks the cycles on which the input is taken, and bit k marks the output rate of stage k. When a slot arrives with the valid flag low, the block inserts a zero. Data offered outside the slots is ignored. Each stage uses the symmetric 7-tap kernel (−1, 0, 9, 16, 9, 0, −1)/16. It computes only the four non-trivial taps on one output phase, and passes the delayed centre sample on the other phase.

A two-state controller governs mode changes. `S_FLUSH` is the reset state. In it the controller clears every delay line, restarts the phase counter, latches the mode code and holds the output invalid. `S_FLUSH` always moves to `S_RUN` after one cycle. `S_RUN` stays in `S_RUN` while the mode input equals the latched code. It returns to `S_FLUSH` on the first cycle in which they differ.

Top module: `hb_interp_chain`

## Requirements
- R1: The mode code selects the number of active stages m: code 0 gives m=0 (bypass), codes 1 to 4 give m equal to the code (factor 2^m), and codes 5 to 7 act as bypass.
- R2: With a constant input on both rails, every interpolating mode settles to an output equal to the input on each rail (unity DC gain).
- R3: Each stage, given input x, emits in order (−x[n] + 9x[n−1] + 9x[n−2] − x[n−3] + 8) >> 4 (arithmetic shift) followed by x[n−1]. In 2× mode, an impulse of 1600 on I therefore appears at the output as −100, 0, 900, 1600, 900, 0, −100.
- R4: Each stage result saturates to the signed W-bit range: with W=16, a ±32767 square wave of period four input samples drives the 2× output to exactly 32767 and −32768.
- R5: In S_RUN with m active stages, rate_stb[0] is high on one cycle in every 2^m, rate_stb[k] for 1 ≤ k ≤ m is high on one cycle in every 2^(m−k), and rate_stb[m] is high on every cycle.
- R6: The input is sampled only on cycles where rate_stb[0] is high. When in_valid is low on such a cycle, a zero sample enters the chain. Data and valid on other cycles have no effect.
- R7: In bypass, out_i/out_q equal the previous cycle's in_i/in_q when in_valid was high, and zero when it was low.
- R8: During reset and in the first cycle after it, out_valid, the outputs and rate_stb are all zero; out_valid rises in the second cycle after reset release.
- R9: A change of the mode input causes exactly one cycle of out_valid low, with zero outputs. After that cycle no history from before the change reaches the output.
- R10: Stages with an index at or above m receive no strobes (rate_stb[k]=0 for k>m) and hold their registers.
- R11: The I and Q rails use the same kernel with equal latency: an impulse of −1600 on Q appears in the same cycles as the I response, with the opposite sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, output sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | $clog2(NST+1) | Interpolation mode code |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | W | Input I sample, signed |
| in_q | input | W | Input Q sample, signed |
| out_valid | output | 1 | Output sample valid |
| out_i | output | W | Output I sample, signed |
| out_q | output | W | Output Q sample, signed |
| rate_stb | output | NST+1 | Bit 0 input slot strobe; bit k output strobe of stage k |

## Verification
A stale or misaligned phase counter shows at rate_stb on the very cycle it goes wrong, so the bench counts the strobes over a 64-cycle window in every mode. A corrupted delay line or a missed flush leaks an old sample. It reaches the output within a few input-rate periods, as a nonzero value after the single invalid cycle or as a deviation from the exact impulse sequence. A wrong saturation or rounding step shows up as the extreme output value of a square-wave stimulus, within the first handful of input samples.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    // Controller states: clear-and-latch, then free running.
    typedef enum logic [0:0] {
        S_FLUSH = 1'b0,
        S_RUN   = 1'b1
    } chain_state_e;

    // Map a mode code to the number of stages in use; unknown codes bypass.
    function automatic int active_stages(input int code, input int nst);
        return ((code >= 1) && (code <= nst)) ? code : 0;
    endfunction

endpackage

// File: rtl/hbi_rate_gen.sv
module hbi_rate_gen #(
    parameter  int NST = 4,
    localparam int SW  = $clog2(NST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [SW-1:0] n_act,
    output logic [NST:0]  stb
);

    logic [NST-1:0] cnt_q;

    // Free-running phase counter, restarted by a flush.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + NST'(1);
        end
    end

    // Strobe k has period 2^(n_act-k): high when the low bits of the counter are all ones.
    for (genvar k = 0; k <= NST; k++) begin : g_stb
        int               expo;
        logic [NST:0]     mask;
        logic             hit;

        always_comb begin
            expo = int'(n_act) - k;
            mask = '0;
            hit  = 1'b0;
            if (run && (expo >= 0)) begin
                mask = ((NST+1)'(1) << expo) - (NST+1)'(1);
                hit  = ((cnt_q & mask[NST-1:0]) == mask[NST-1:0]);
            end
        end

        assign stb[k] = hit;

        if (k < NST) begin : g_nest
            // A slower strobe always lands on a cycle of the next faster one.
            AST_STB_NEST: assert property (@(posedge clk) disable iff (!rst_n)
                (stb[k] && (int'(n_act) > k)) |-> stb[k+1]); // R5
        end
    end

endmodule

// File: rtl/hbi_halfband.sv
module hbi_halfband #(
    parameter  int W  = 16,
    localparam int AW = W + 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                in_en,
    input  logic                out_en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] y
);

    logic signed [W-1:0]  x0_q, x1_q, x2_q, y_q;
    logic signed [AW-1:0] pair, acc, scaled;
    logic signed [W-1:0]  tap_val;

    // Non-trivial phase: -x[n] + 9(x[n-1] + x[n-2]) - x[n-3], rounded, /16.
    always_comb begin
        pair   = AW'(x0_q) + AW'(x1_q);
        acc    = (pair <<< 3) + pair - AW'(din) - AW'(x2_q) + AW'(8);
        scaled = acc >>> 4;
        if ((&scaled[AW-1:W-1]) || (~|scaled[AW-1:W-1])) begin
            tap_val = scaled[W-1:0];
        end else if (scaled[AW-1]) begin
            tap_val = {1'b1, {(W-1){1'b0}}};
        end else begin
            tap_val = {1'b0, {(W-1){1'b1}}};
        end
    end

    // in_en marks the phase that takes a new sample; the other phase emits the centre tap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x0_q <= '0;
            x1_q <= '0;
            x2_q <= '0;
            y_q  <= '0;
        end else if (clr) begin
            x0_q <= '0;
            x1_q <= '0;
            x2_q <= '0;
            y_q  <= '0;
        end else if (out_en) begin
            if (in_en) begin
                x0_q <= din;
                x1_q <= x0_q;
                x2_q <= x1_q;
                y_q  <= tap_val;
            end else begin
                y_q  <= x1_q;
            end
        end
    end

    assign y = y_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && !clr) |=> ($stable(x0_q) && $stable(x1_q) && $stable(x2_q) && $stable(y_q))); // R10

    AST_IN_NEEDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        in_en |-> out_en); // R5

endmodule

// File: rtl/hb_interp_chain.sv
module hb_interp_chain
    import hbi_pkg::*;
#(
    parameter  int W   = 16,
    parameter  int NST = 4,
    localparam int MW  = $clog2(NST + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MW-1:0]       mode,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_i,
    input  logic signed [W-1:0] in_q,
    output logic                out_valid,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q,
    output logic [NST:0]        rate_stb
);

    chain_state_e        state_q, state_d;
    logic [MW-1:0]       mode_q, n_act;
    logic                clr, run;
    logic signed [W-1:0] yi [NST];
    logic signed [W-1:0] yq [NST];
    logic signed [W-1:0] sel_i, sel_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_FLUSH;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FLUSH: state_d = S_RUN;
            S_RUN:   if (mode != mode_q) state_d = S_FLUSH;
        endcase
    end

    // State outputs.
    always_comb begin
        clr = 1'b0;
        run = 1'b0;
        unique case (state_q)
            S_FLUSH: clr = 1'b1;
            S_RUN:   run = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (clr) begin
            mode_q <= mode;
        end
    end

    assign n_act = MW'(active_stages(int'(mode_q), NST));

    hbi_rate_gen #(.NST(NST)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .run   (run),
        .n_act (n_act),
        .stb   (rate_stb)
    );

    for (genvar j = 0; j < NST; j++) begin : g_stage
        logic signed [W-1:0] di, dq;
        logic                en_in, en_out;

        assign en_out = rate_stb[j+1];
        assign en_in  = rate_stb[j] && (int'(n_act) > j);

        if (j == 0) begin : g_head
            assign di = in_valid ? in_i : '0;
            assign dq = in_valid ? in_q : '0;
        end else begin : g_body
            assign di = yi[j-1];
            assign dq = yq[j-1];
        end

        hbi_halfband #(.W(W)) u_rail_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .in_en  (en_in),
            .out_en (en_out),
            .din    (di),
            .y      (yi[j])
        );

        hbi_halfband #(.W(W)) u_rail_q (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .in_en  (en_in),
            .out_en (en_out),
            .din    (dq),
            .y      (yq[j])
        );
    end

    // Bypass takes the input directly; otherwise the last stage in use.
    always_comb begin
        if (n_act == '0) begin
            sel_i = in_valid ? in_i : '0;
            sel_q = in_valid ? in_q : '0;
        end else begin
            sel_i = yi[n_act - MW'(1)];
            sel_q = yq[n_act - MW'(1)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else if (run) begin
            out_valid <= 1'b1;
            out_i     <= sel_i;
            out_q     <= sel_q;
        end else begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end
    end

    AST_FLUSH_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FLUSH) |=> (!out_valid && (out_i == '0) && (out_q == '0))); // R9

    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_RUN) && (mode != mode_q)) |=> ##1 !out_valid); // R9

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_RUN) && (n_act == '0) && in_valid)
            |=> ((out_i == $past(in_i)) && (out_q == $past(in_q)))); // R7

endmodule

// File: tb/hb_interp_chain_test.sv
module hb_interp_chain_test;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [2:0]         mode = 3'd1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic               out_valid;
    logic signed [15:0] out_i, out_q;
    logic [4:0]         rate_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct packed { int mode; int di; int dq; int ei; int eq; } vec_t;
    localparam vec_t VT [6] = '{
        '{1,  1000, -2000,  1000, -2000},
        '{2, -1234,   777, -1234,   777},
        '{3, 32767, -32768, 32767, -32768},
        '{4,     5,    -5,     5,    -5},
        '{0,   300,  -300,   300,  -300},
        '{7,    -9,     9,    -9,     9}
    };

    hb_interp_chain uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q),
        .rate_stb  (rate_stb)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_take();
        do @(negedge clk); while (!rate_stb[0]);
    endtask

    task automatic square_run(input int amp, output int mx, output int mn);
        int p;
        p  = 0;
        mx = -100000;
        mn = 100000;
        for (int c = 0; c < 120; c++) begin
            @(negedge clk);
            if (c >= 20) begin
                if (int'(out_i) > mx) mx = int'(out_i);
                if (int'(out_i) < mn) mn = int'(out_i);
            end
            if (rate_stb[0]) begin
                in_i = ((p % 4) < 2) ? 16'(amp) : 16'(-amp);
                p++;
            end
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt [5];
        int m, ex, mx, mn, lows, bad, f;
        int ri [30];
        int rq [30];
        int imp [7];
        logic pv;
        logic signed [15:0] pi;

        imp = '{-100, 0, 900, 1600, 900, 0, -100};

        // R8: reset state
        repeat (3) @(negedge clk);
        chk(!out_valid && out_i == 0 && out_q == 0, "R8 valid/out in reset", int'(out_valid), 0);
        chk(rate_stb == '0, "R8 strobes in reset", int'(rate_stb), 0);
        rst_n = 1'b1;
        chk(rate_stb == '0 && !out_valid, "R8 first cycle after reset", int'(rate_stb), 0);
        @(negedge clk);
        chk(!out_valid, "R8 valid still low", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid, "R8 valid rises", int'(out_valid), 1);

        // Vector table: R1 R2 R5 R7 R10
        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            mode     = 3'(VT[v].mode);
            in_i     = 16'(VT[v].di);
            in_q     = 16'(VT[v].dq);
            in_valid = 1'b1;
            repeat (300) @(negedge clk);
            m = (VT[v].mode >= 1 && VT[v].mode <= 4) ? VT[v].mode : 0;
            chk(out_valid && int'(out_i) == VT[v].ei, "R1 R2 R7 settled I", int'(out_i), VT[v].ei);
            chk(int'(out_q) == VT[v].eq, "R2 R11 settled Q", int'(out_q), VT[v].eq);
            for (int k = 0; k < 5; k++) cnt[k] = 0;
            repeat (64) begin
                @(negedge clk);
                for (int k = 0; k < 5; k++) if (rate_stb[k]) cnt[k]++;
            end
            for (int k = 0; k < 5; k++) begin
                ex = (k <= m) ? (64 >> (m - k)) : 0;
                chk(cnt[k] == ex, "R5 R10 strobe count", cnt[k], ex);
            end
        end

        // R3 R11: impulse response in 2x mode
        @(negedge clk);
        mode = 3'd1; in_i = '0; in_q = '0; in_valid = 1'b1;
        repeat (20) @(negedge clk);
        wait_take();
        in_i = 16'sd1600; in_q = -16'sd1600;
        @(negedge clk);
        in_i = '0; in_q = '0;
        for (int s = 0; s < 30; s++) begin
            @(negedge clk);
            ri[s] = int'(out_i);
            rq[s] = int'(out_q);
        end
        f = -1;
        for (int s = 0; s < 30; s++) if (f < 0 && ri[s] != 0) f = s;
        chk(f >= 0 && f < 20, "R3 impulse present", f, 0);
        if (f < 0 || f >= 20) f = 0;
        for (int t = 0; t < 7; t++) begin
            chk(ri[f+t] == imp[t], "R3 impulse I tap", ri[f+t], imp[t]);
            chk(rq[f+t] == -imp[t], "R11 impulse Q tap", rq[f+t], -imp[t]);
        end
        chk(ri[f+7] == 0 && ri[f+8] == 0, "R3 impulse tail", ri[f+7], 0);

        // R6: valid-low slots insert zero, off-slot data ignored
        bad = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (out_i != 0 || out_q != 0) bad++;
            if (rate_stb[0]) begin
                in_valid = 1'b0; in_i = 16'sd7000; in_q = 16'sd7000;
            end else begin
                in_valid = 1'b1; in_i = 16'sd5000; in_q = 16'sd5000;
            end
        end
        chk(bad == 0, "R6 nonzero outputs", bad, 0);
        in_valid = 1'b1; in_i = '0; in_q = '0;
        repeat (20) @(negedge clk);

        // R3 R4: square wave, rounding and saturation
        square_run(1000, mx, mn);
        chk(mx == 1250, "R3 square max", mx, 1250);
        chk(mn == -1250, "R3 square min", mn, -1250);
        square_run(32767, mx, mn);
        chk(mx == 32767, "R4 saturate high", mx, 32767);
        chk(mn == -32768, "R4 saturate low", mn, -32768);

        // R9: flush on mode change
        @(negedge clk);
        mode = 3'd4; in_i = 16'sd20000; in_q = -16'sd20000;
        repeat (300) @(negedge clk);
        chk(int'(out_i) == 20000, "R2 16x settled", int'(out_i), 20000);
        mode = 3'd1; in_i = '0; in_q = '0;
        lows = 0; bad = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (!out_valid) lows++;
            else if (lows > 0 && (out_i != 0 || out_q != 0)) bad++;
        end
        chk(lows == 1, "R9 invalid cycles", lows, 1);
        chk(bad == 0, "R9 stale history", bad, 0);

        // R7: bypass follows input by one cycle
        mode = 3'd0;
        repeat (5) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            pv = ((i % 3) != 0);
            pi = 16'(100 * i + 7);
            in_valid = pv; in_i = pi; in_q = -pi;
            @(negedge clk);
            chk(out_i == (pv ? pi : 16'sd0) && out_q == (pv ? -pi : 16'sd0),
                "R7 bypass sample", int'(out_i), pv ? int'(pi) : 0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule